// File: doc/BRIEF.md
# Vector Lane Shifter

This unit shifts every element of a 128-bit vector in a single registered stage. The caller picks the element width at run time: 8, 16, 32 or 64 bits. The vector is therefore treated as 16, 8, 4 or 2 independent lanes. No bit, carry or sign ever passes from one lane into its neighbour.

Three shift kinds are available: left, logical right and arithmetic right. The shift amount can be taken per lane from the matching lane of a second vector. It can also be one scalar amount that applies to all lanes. The scalar amount is a 12-bit displacement, optionally added to a 64-bit base value. Each amount is reduced to the low bits that fit the lane width, so the effective shift is always smaller than the element.

An element-size code outside the legal set, or an opcode that is not one of the six shift opcodes, raises an exception flag instead of a result. In that case the result register keeps its previous contents.

Top module: `vshift_unit`

## Requirements
- R1: After reset, validOut and specExc are 0 and result is all zeros.
- R2: validOut is high exactly one cycle after a cycle in which validIn is high. When validIn is low, validOut falls and result keeps its value.
- R3: sizeCode 0, 1, 2 and 3 select 8, 16, 32 and 64-bit lanes. Lane 0 occupies the most significant bits, and further lanes follow toward bit 0. No lane's result depends on another lane's data.
- R4: A left shift fills vacated bits with zeros and drops bits that move past the top of the lane.
- R5: A logical right shift fills vacated bits with zeros.
- R6: An arithmetic right shift fills vacated bits with the top bit of that lane's own element.
- R7: In the per-lane form, the amount for a lane comes from the same lane of vecB, using only its low log2(lane width) bits.
- R8: In the broadcast form, the amount is disp plus baseVal when baseSel is nonzero, or disp alone when baseSel is zero. The sum is then reduced to its low log2(lane width) bits and applied to every lane.
- R9: The opSel encodings are as follows. 8'h70 selects per-lane left, 8'h78 per-lane logical right and 8'h7A per-lane arithmetic right. 8'h30 selects broadcast left, 8'h38 broadcast logical right and 8'h3A broadcast arithmetic right.
- R10: A request with sizeCode above 3 sets specExc together with validOut on the next cycle and leaves result unchanged.
- R11: A request with any other opSel value is handled the same way as in R10: specExc is raised and result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Request strobe |
| opSel | input | 8 | Operation code |
| sizeCode | input | 4 | Element size code |
| vecA | input | 128 | Elements to be shifted |
| vecB | input | 128 | Per-lane shift amounts |
| disp | input | 12 | Broadcast displacement |
| baseSel | input | 4 | Base register field; nonzero adds baseVal |
| baseVal | input | 64 | Base value for the broadcast amount |
| validOut | output | 1 | Response strobe, one cycle after validIn |
| result | output | 128 | Shifted vector |
| specExc | output | 1 | Exception: illegal size code or opcode |

## Verification
The assertions assume that validIn, opSel and sizeCode are known values at every rising edge once reset is released. They also assume that reset is held long enough for the output register to clear. The bench drives every input on the falling edge, so nothing changes near the sampling edge. It keeps validIn at 0 throughout reset. Random requests draw opcodes only from the six legal values and size codes only from 0 to 3. Illegal codes are injected only in directed steps whose expected outcome is the exception.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  localparam int VEC_W     = 128;
  localparam int MIN_ELEM  = 8;
  localparam int NUM_SIZES = 4;
  localparam int OP_W      = 8;
  localparam int SIZE_W    = 4;
  localparam int SEL_W     = $clog2(NUM_SIZES);

  localparam logic [OP_W-1:0] OP_LANE_LEFT   = 8'h70;
  localparam logic [OP_W-1:0] OP_LANE_LRIGHT = 8'h78;
  localparam logic [OP_W-1:0] OP_LANE_ARIGHT = 8'h7A;
  localparam logic [OP_W-1:0] OP_BC_LEFT     = 8'h30;
  localparam logic [OP_W-1:0] OP_BC_LRIGHT   = 8'h38;
  localparam logic [OP_W-1:0] OP_BC_ARIGHT   = 8'h3A;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'd0,
    SH_LRIGHT = 2'd1,
    SH_ARIGHT = 2'd2
  } shKind_e;

  typedef struct packed {
    logic             fire;
    logic             load;
    logic             exc;
    logic             perLane;
    shKind_e          kind;
    logic [SEL_W-1:0] size;
  } ctrl_t;
endpackage

// File: rtl/vshift_ctrl.sv
module vshift_ctrl
  import vshift_pkg::*;
(
  input  logic              validIn,
  input  logic [OP_W-1:0]   opSel,
  input  logic [SIZE_W-1:0] sizeCode,
  output ctrl_t             ctrl
);
  logic    opLegal;
  logic    sizeLegal;
  logic    perLane;
  shKind_e kind;

  always_comb begin
    opLegal = 1'b1;
    perLane = 1'b0;
    kind    = SH_LEFT;
    unique case (opSel)
      OP_LANE_LEFT:   begin perLane = 1'b1; kind = SH_LEFT;   end
      OP_LANE_LRIGHT: begin perLane = 1'b1; kind = SH_LRIGHT; end
      OP_LANE_ARIGHT: begin perLane = 1'b1; kind = SH_ARIGHT; end
      OP_BC_LEFT:     kind = SH_LEFT;
      OP_BC_LRIGHT:   kind = SH_LRIGHT;
      OP_BC_ARIGHT:   kind = SH_ARIGHT;
      default:        opLegal = 1'b0;
    endcase
  end

  assign sizeLegal = (sizeCode < SIZE_W'(NUM_SIZES));

  always_comb begin
    ctrl.fire    = validIn;
    ctrl.load    = validIn & opLegal & sizeLegal;
    ctrl.exc     = validIn & ~(opLegal & sizeLegal);
    ctrl.perLane = perLane;
    ctrl.kind    = kind;
    ctrl.size    = sizeCode[SEL_W-1:0];
  end
endmodule

// File: rtl/vshift_datapath.sv
module vshift_datapath
  import vshift_pkg::*;
#(
  parameter int VW     = VEC_W,
  parameter int CNT_W  = 64,
  parameter int DISP_W = 12,
  parameter int BSEL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [VW-1:0]     vecA,
  input  logic [VW-1:0]     vecB,
  input  logic [DISP_W-1:0] disp,
  input  logic [BSEL_W-1:0] baseSel,
  input  logic [CNT_W-1:0]  baseVal,
  output logic              validOut,
  output logic              specExc,
  output logic [VW-1:0]     result
);
  logic [CNT_W-1:0] scalarAmt;
  logic [NUM_SIZES-1:0][VW-1:0] sizeRes;
  logic [VW-1:0] nextRes;
  logic unusedBits;

  assign scalarAmt  = CNT_W'(disp) + ((baseSel != '0) ? baseVal : '0);
  assign unusedBits = ^{vecB, scalarAmt};

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int W  = MIN_ELEM << s;
    localparam int NL = VW / W;
    localparam int CW = $clog2(W);
    for (genvar l = 0; l < NL; l++) begin : g_lane
      localparam int LO = VW - (l + 1) * W;
      logic [W-1:0]  elem;
      logic [W-1:0]  laneOut;
      logic [CW-1:0] amt;
      assign elem = vecA[LO +: W];
      assign amt  = ctrl.perLane ? vecB[LO +: CW] : scalarAmt[CW-1:0];
      always_comb begin
        case (ctrl.kind)
          SH_LEFT:   laneOut = elem << amt;
          SH_LRIGHT: laneOut = elem >> amt;
          SH_ARIGHT: laneOut = W'($signed(elem) >>> amt);
          default:   laneOut = elem;
        endcase
      end
      assign sizeRes[s][LO +: W] = laneOut;
    end
  end

  assign nextRes = sizeRes[ctrl.size];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut <= 1'b0;
      specExc  <= 1'b0;
      result   <= '0;
    end else begin
      validOut <= ctrl.fire;
      specExc  <= ctrl.exc;
      if (ctrl.load) result <= nextRes;
    end
  end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
  import vshift_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          validIn,
  input  logic [7:0]    opSel,
  input  logic [3:0]    sizeCode,
  input  logic [127:0]  vecA,
  input  logic [127:0]  vecB,
  input  logic [11:0]   disp,
  input  logic [3:0]    baseSel,
  input  logic [63:0]   baseVal,
  output logic          validOut,
  output logic [127:0]  result,
  output logic          specExc
);
  ctrl_t ctrl;

  vshift_ctrl i_ctrl (
    .validIn (validIn),
    .opSel   (opSel),
    .sizeCode(sizeCode),
    .ctrl    (ctrl)
  );

  vshift_datapath #(
    .VW(128), .CNT_W(64), .DISP_W(12), .BSEL_W(4)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .vecA    (vecA),
    .vecB    (vecB),
    .disp    (disp),
    .baseSel (baseSel),
    .baseVal (baseVal),
    .validOut(validOut),
    .specExc (specExc),
    .result  (result)
  );
endmodule

// File: rtl/vshift_checker.sv
module vshift_checker (
  input logic         clk,
  input logic         rstN,
  input logic         validIn,
  input logic [7:0]   opSel,
  input logic [3:0]   sizeCode,
  input logic         validOut,
  input logic         specExc,
  input logic [127:0] result
);
  logic legalOp;
  assign legalOp = (opSel == 8'h70) || (opSel == 8'h78) || (opSel == 8'h7A) ||
                   (opSel == 8'h30) || (opSel == 8'h38) || (opSel == 8'h3A);

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!validOut && $stable(result)));

  a_r10_size_exc: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && sizeCode > 4'd3) |=> (specExc && validOut));

  a_r11_op_exc: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !legalOp) |=> specExc);

  a_r10_exc_holds_result: assert property (@(posedge clk) disable iff (!rstN)
    specExc |-> $stable(result));

  a_r9_legal_no_exc: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && legalOp && sizeCode <= 4'd3) |=> !specExc);
endmodule

bind vshift_unit vshift_checker i_chk (.*);

// File: tb/test_vshift_unit.sv
module test_vshift_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [7:0]   opSel = '0;
  logic [3:0]   sizeCode = '0;
  logic [127:0] vecA = '0, vecB = '0;
  logic [11:0]  disp = '0;
  logic [3:0]   baseSel = '0;
  logic [63:0]  baseVal = '0;
  logic         validOut, specExc;
  logic [127:0] result;

  int nChecks = 0;
  int nFails = 0;
  logic [127:0] lastRes = '0;
  logic [7:0] opList [6] = '{8'h70, 8'h78, 8'h7A, 8'h30, 8'h38, 8'h3A};

  vshift_unit i_vshift_unit (.*);

  always #5 clk = ~clk;

  function automatic logic [127:0] model(input logic [7:0] op, input logic [1:0] sz,
      input logic [127:0] a, input logic [127:0] b, input logic [11:0] d,
      input logic [3:0] bs, input logic [63:0] bv);
    int w;
    logic [63:0] m, sc, e, c, r;
    logic [127:0] res;
    w = 8 << sz;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sc = {52'd0, d} + ((bs != 4'd0) ? bv : 64'd0);
    res = '0;
    for (int l = 0; l < 128 / w; l++) begin
      int lo;
      lo = 128 - (l + 1) * w;
      e = 64'(a >> lo) & m;
      c = op[6] ? (64'(b >> lo) & 64'(w - 1)) : (sc & 64'(w - 1));
      case (op[3:0])
        4'h0:    r = (e << c) & m;
        4'h8:    r = e >> c;
        default: begin
          r = e >> c;
          if (e[w-1]) r = r | (~(m >> c) & m);
        end
      endcase
      res = res | (128'(r) << lo);
    end
    return res;
  endfunction

  function automatic string opTag(input logic [7:0] op);
    string t;
    case (op[3:0])
      4'h0: t = "R4";
      4'h8: t = "R5";
      default: t = "R6";
    endcase
    return {t, op[6] ? "/R7/R9" : "/R8/R9"};
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
      input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [3:0] sz, input logic [127:0] a,
      input logic [127:0] b, input logic [11:0] d, input logic [3:0] bs,
      input logic [63:0] bv, input string req);
    logic illegal;
    logic [127:0] exp;
    illegal = (sz > 4'd3) || !(op == 8'h70 || op == 8'h78 || op == 8'h7A ||
                               op == 8'h30 || op == 8'h38 || op == 8'h3A);
    @(negedge clk);
    validIn = 1'b1; opSel = op; sizeCode = sz; vecA = a; vecB = b;
    disp = d; baseSel = bs; baseVal = bv;
    @(negedge clk);
    validIn = 1'b0;
    if (illegal) begin
      exp = lastRes;
      check(validOut && specExc && result == exp, req, result, exp);
    end else begin
      exp = model(op, sz[1:0], a, b, d, bs, bv);
      check(validOut && !specExc && result == exp, req, result, exp);
      lastRes = exp;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [127:0] a;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(!validOut && !specExc && result == '0, "R1 reset state",
          {126'd0, validOut, specExc} | result, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: mask equal to and above lane width in broadcast form
    for (int s = 0; s < 4; s++) begin
      a = rnd128();
      run(8'h30, 4'(s), a, '0, 12'(8 << s), 4'd0, '0, "R8 count equals width");
      check(result == a, "R8 masked to zero", result, a);
      run(8'h38, 4'(s), a, '0, 12'((8 << s) + 3), 4'd0, '0, "R8 count above width");
    end
    // R8: base added only when base field nonzero
    run(8'h30, 4'd0, rnd128(), '0, 12'd2, 4'd1, 64'd5, "R8 base added");
    run(8'h3A, 4'd1, rnd128(), '0, 12'd1, 4'd0, 64'hFFFF_FFFF_FFFF_FFF0, "R8 base ignored");
    // R7: per-lane counts of all ones mask to width-1
    run(8'h70, 4'd0, rnd128(), {16{8'hFF}}, '0, '0, '0, "R7 lane count masked");
    // R6 and R3: sign stays inside each lane
    run(8'h7A, 4'd0, {16{8'h80}}, {16{8'h07}}, '0, '0, '0, "R6 byte sign fill");
    check(result == {16{8'hFF}}, "R6 byte sign fill value", result, {16{8'hFF}});
    run(8'h7A, 4'd1, {8{16'h0080}}, {8{16'h0007}}, '0, '0, '0, "R3 no cross-lane sign");
    check(result == {8{16'h0001}}, "R3 no cross-lane value", result, {8{16'h0001}});
    // R3: lane 0 at the top, distinct counts per lane
    run(8'h70, 4'd3, {64'd1, 64'd1}, {64'd4, 64'd1}, '0, '0, '0, "R3 lane order");
    check(result == {64'd16, 64'd2}, "R3 lane order value", result, {64'd16, 64'd2});
    // R10 / R11: exceptions hold the result
    for (int s = 4; s < 16; s += 5)
      run(8'h70, 4'(s), rnd128(), rnd128(), '0, '0, '0, "R10 illegal size");
    run(8'h31, 4'd0, rnd128(), rnd128(), '0, '0, '0, "R11 illegal opcode");
    // R2: idle cycle
    @(negedge clk);
    check(!validOut && result == lastRes, "R2 idle hold", result, lastRes);
    // random requests
    for (int i = 0; i < 800; i++) begin
      logic [7:0] op;
      op = opList[$urandom_range(0, 5)];
      run(op, 4'($urandom_range(0, 3)), rnd128(), rnd128(), 12'($urandom),
          4'($urandom_range(0, 3)), {$urandom, $urandom}, opTag(op));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule